// File: doc/BRIEF.md
# Row/Column Multiplexed Programming Port

This block is the front end of a parallel programming port for a non-volatile memory core. An external programmer presents an 18-bit byte address over an 11-line address bus, split into two halves. A single row/column select strobe moves the halves in. The low half is taken when the strobe falls, and the high half is taken from the lowest seven lines when it rises. Write-enable, output-enable and an interface reset complete the pin set. The block turns these pins into simple requests that the core runs on its fast system clock.

All programmer strobes reach the system clock domain through two-flop synchronisers. Edges are detected on the synchronised copies. A completed write becomes a single-cycle command strobe to the core, carrying the full address and the data byte. A read is a level request, and the block returns the core's byte on the data output under a separate output-enable for the shared 8-bit bus. Timing checks on the pins, command decoding and the storage array are not part of this block.

Top module: `rc_prog_port`

## Requirements
- R1: On a falling edge of the row/column select (`rc_n`), the low address bits [10:0] of `core_addr` take the value of `addr_in[10:0]`.
- R2: On a rising edge of `rc_n`, address bits [17:11] of `core_addr` take `addr_in[6:0]`. The lines `addr_in[10:7]` have no effect on that half.
- R3: A rising edge of `we_n` while `oe_n` and `rp_n` are both high gives exactly one system-clock pulse on `core_wr_stb` within six clocks. During the pulse, `core_wdata` equals `dq_in` and `core_addr` equals {high half, low half}.
- R4: A rising edge of `we_n` while `oe_n` is low gives no pulse on `core_wr_stb`.
- R5: With `we_n` high, `rp_n` high and `oe_n` low, `dq_oe` is 1, `core_rd_req` is 1 and `dq_out` equals `core_rdata`.
- R6: While `oe_n` is high, `dq_oe` is 0 and `core_rd_req` is 0, whatever `we_n` and `rp_n` are.
- R7: While `rp_n` is low, `dq_oe` is 0, no write pulse occurs, `core_addr` is held at zero and edges on `rc_n` are ignored. After `rp_n` returns high, the port is in read mode: with `we_n` high and `oe_n` low, `dq_oe` is 1 and `core_addr` is still zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| addr_in | input | 11 | Multiplexed address lines |
| rc_n | input | 1 | Row/column select strobe |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rp_n | input | 1 | Interface reset, active low |
| dq_in | input | 8 | Data bus input |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus drive enable |
| core_wr_stb | output | 1 | One-cycle write command strobe |
| core_addr | output | 18 | Assembled byte address |
| core_wdata | output | 8 | Write data byte |
| core_rd_req | output | 1 | Read request level |
| core_rdata | input | 8 | Read data from the core |

## Verification
The hardest case to reach is a write edge that must be rejected, or a strobe edge that must be ignored. Each of these stays invisible unless the bench first puts a known non-zero address in place and then watches the strobe count over the whole synchroniser window. The bench sweeps many row and column values. It loads the column with junk on the upper lines, and it follows each suppressed edge with a pulse count and an address readback through `core_addr`. Interface reset is entered with a non-zero address latched, so that the clearing and the ignored strobes both show at the ports.

// File: rtl/rc_prog_port.sv
module rc_prog_port #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W-1:0]       addr_in,
  input  logic                   rc_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic                   rp_n,
  input  logic [DATA_W-1:0]      dq_in,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   dq_oe,
  output logic                   core_wr_stb,
  output logic [ROW_W+COL_W-1:0] core_addr,
  output logic [DATA_W-1:0]      core_wdata,
  output logic                   core_rd_req,
  input  logic [DATA_W-1:0]      core_rdata
);
  localparam int ADDR_W = ROW_W + COL_W;

  logic [2:0] rc_s, we_s;
  logic [1:0] oe_s, rp_s;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic rc_fall, rc_rise, we_rise, wr_fire, rd_en, live;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rc_s <= 3'b111;
      we_s <= 3'b111;
      oe_s <= 2'b11;
      rp_s <= 2'b00;
    end else begin
      rc_s <= {rc_s[1:0], rc_n};
      we_s <= {we_s[1:0], we_n};
      oe_s <= {oe_s[0], oe_n};
      rp_s <= {rp_s[0], rp_n};
    end

  assign live    = rp_s[1];
  assign rc_fall = !rc_s[1] && rc_s[2];
  assign rc_rise = rc_s[1] && !rc_s[2];
  assign we_rise = we_s[1] && !we_s[2];
  assign wr_fire = we_rise && oe_s[1] && live;
  assign rd_en   = live && we_s[1] && !oe_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (!live) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (rc_fall) row_q <= addr_in;
      if (rc_rise) col_q <= addr_in[COL_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      core_wr_stb <= 1'b0;
      core_wdata  <= '0;
    end else begin
      core_wr_stb <= wr_fire;
      if (wr_fire) core_wdata <= dq_in;
    end

  assign core_addr   = {col_q, row_q};
  assign core_rd_req = rd_en;
  assign dq_oe       = rd_en;
  assign dq_out      = rd_en ? core_rdata : '0;

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_stb |=> !core_wr_stb);
  // R4
  wr_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_stb |-> $past(!dq_oe));
  // R7
  rp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (core_addr == '0));
  // R2
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_s[1] && live) |=> $stable(col_q));
  // R1
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_s[1] && live) |=> $stable(row_q));
  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_s[1]) && oe_s[1] |-> !dq_oe);
endmodule

// File: tb/rc_prog_port_test.sv
module rc_prog_port_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [10:0] addr_in = '0;
  logic rc_n = 1, we_n = 1, oe_n = 1, rp_n = 0;
  logic [7:0] dq_in = '0, dq_out, core_wdata, core_rdata;
  logic dq_oe, core_wr_stb, core_rd_req;
  logic [17:0] core_addr, cap_addr;
  logic [7:0] cap_data;
  int pulses = 0, checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rc_prog_port uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .rc_n(rc_n), .we_n(we_n),
    .oe_n(oe_n), .rp_n(rp_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .core_wr_stb(core_wr_stb), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rd_req(core_rd_req), .core_rdata(core_rdata)
  );

  assign core_rdata = core_addr[7:0] ^ 8'h5A;

  always @(posedge clk)
    if (core_wr_stb) begin
      pulses++;
      cap_addr = core_addr;
      cap_data = core_wdata;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_addr(input logic [17:0] a, input logic [3:0] junk);
    addr_in = a[10:0]; wait_cyc(3);
    rc_n = 0;          wait_cyc(5);
    addr_in = {junk, a[17:11]}; wait_cyc(3);
    rc_n = 1;          wait_cyc(5);
  endtask

  task automatic pulse_we(input logic [7:0] d);
    dq_in = d; wait_cyc(2);
    we_n = 0;  wait_cyc(5);
    we_n = 1;  wait_cyc(7);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(4);
    chk("R7 reset dq_oe", dq_oe, 0);
    chk("R7 reset addr", core_addr, 0);
    chk("R3 reset strobe", core_wr_stb, 0);
    rp_n = 1; wait_cyc(4);

    for (int i = 0; i < 64; i++) begin
      logic [17:0] a;
      logic [7:0] d;
      int p0;
      a = 18'((i * 4099 + 37) % 262144);
      if (i == 1) a = 18'h3FFFF;
      if (i == 2) a = 18'h00000;
      d = 8'((i * 29 + 3) % 256);
      load_addr(a, 4'(15 - i % 16));
      chk("R1 row", core_addr[10:0], a[10:0]);
      chk("R2 column", core_addr[17:11], a[17:11]);
      p0 = pulses;
      pulse_we(d);
      chk("R3 one pulse", pulses - p0, 1);
      chk("R3 addr", cap_addr, a);
      chk("R3 data", cap_data, d);
      oe_n = 0; wait_cyc(4);
      chk("R5 dq_oe", dq_oe, 1);
      chk("R5 rd_req", core_rd_req, 1);
      chk("R5 dq_out", dq_out, a[7:0] ^ 8'h5A);
      p0 = pulses;
      pulse_we(~d);
      chk("R4 no pulse with oe low", pulses - p0, 0);
      oe_n = 1; wait_cyc(4);
    end

    for (int c = 0; c < 8; c++) begin
      we_n = c[0]; oe_n = c[1]; rp_n = c[2];
      wait_cyc(5);
      chk("R5/R6/R7 dq_oe combo", dq_oe, (c == 5) ? 1 : 0);
      chk("R5/R6/R7 rd_req combo", core_rd_req, (c == 5) ? 1 : 0);
      if (c[1]) chk("R6 oe high off", dq_oe, 0);
    end
    we_n = 1; oe_n = 1; rp_n = 1; wait_cyc(5);

    load_addr(18'h2A5C3, 4'hF);
    chk("R1 pre-reset", core_addr, 18'h2A5C3);
    begin
      int p0;
      rp_n = 0; oe_n = 0; wait_cyc(5);
      chk("R7 addr cleared", core_addr, 0);
      chk("R7 dq_oe off", dq_oe, 0);
      oe_n = 1;
      load_addr(18'h1B3D7, 4'h0);
      chk("R7 rc ignored", core_addr, 0);
      p0 = pulses;
      pulse_we(8'hC3);
      chk("R7 no write in reset", pulses - p0, 0);
      rp_n = 1; oe_n = 0; wait_cyc(5);
      chk("R7 read mode after release", dq_oe, 1);
      chk("R7 addr zero after release", core_addr, 0);
      chk("R7 dq_out after release", dq_out, 8'h5A);
      oe_n = 1; wait_cyc(4);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule